// File: doc/BRIEF.md
# Receive Flow-Control Credit Advertiser

This block keeps the receive-side flow-control credit accounts of a PCIe-style endpoint. It covers four finite credit kinds: posted header, posted data, non-posted header and non-posted data. For each kind it keeps two counters. One counts the credits that arriving requests have taken. The other is the cumulative credit limit that the endpoint has granted to its link partner, and it moves forward only when internal buffers are handed back. Completion header and completion data credits are infinite, so they are never tracked and never requested.

Whenever buffers are handed back, the block asks the DLLP transmitter for an UpdateFC of that kind. While the link is active, each kind also has its own refresh timer. The timer raises a request when no update for that kind has been sent within the refresh window. A control input lengthens that window four times. A fixed-priority arbiter presents one request at a time, together with the kind and the cumulative count to carry. It keeps that request steady until the transmitter acknowledges it.

Top module: `rx_fc_advertiser`

## Requirements
- R1: After reset `upd_req` is low, and no credits are counted as taken.
- R2: The first counts advertised are 2 for posted header (kind 0), MAX_PAYLOAD_BYTES/16 for posted data (kind 1), 2 for non-posted header (kind 2) and 2 for non-posted data (kind 3).
- R3: A consume of amount A for a kind is accepted only when A does not exceed that kind's available credits, where available = limit − taken. A consume that exceeds this has no effect on any counter.
- R4: A release of amount A for a kind is accepted when A is nonzero and does not exceed the credits in use (taken − (limit − initial)). The kind's limit then rises by A, and `upd_req` is high in the next cycle while the link is up.
- R5: A release of zero, or one larger than the credits in use, changes no count and raises no request.
- R6: Advertised counts wrap modulo 256 for header kinds (0, 2) and modulo 4096 for data kinds (1, 3), zero-extended onto the 12-bit `upd_count`.
- R7: When several kinds are pending, the lowest kind code is granted first, one kind per acknowledge.
- R8: Once `upd_req` is shown without `upd_ack`, the request stays high and `upd_kind` keeps its value until it is acknowledged, even if a higher-priority kind becomes pending. The link must stay up for this to hold.
- R9: While the link is up, a kind with no granted update for REFRESH_SHORT_CYC cycles becomes pending, and `upd_req` rises in cycle REFRESH_SHORT_CYC+1. With `ext_sync` high, REFRESH_LONG_CYC is used instead. A grant for a kind restarts that kind's timer.
- R10: While `link_up` is low, `upd_req` stays low and the refresh timers are held at zero. Releases accepted in that time stay pending until the link comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link in an active state (L0 or L0s) |
| ext_sync | input | 1 | Selects the long refresh window |
| cons_vld | input | 1 | A request has consumed credits |
| cons_kind | input | 2 | Kind consumed (0 PH, 1 PD, 2 NPH, 3 NPD) |
| cons_amt | input | 12 | Credits consumed |
| rel_vld | input | 1 | Buffer space returned |
| rel_kind | input | 2 | Kind returned |
| rel_amt | input | 12 | Credits returned |
| upd_req | output | 1 | UpdateFC wanted |
| upd_kind | output | 2 | Kind of the requested update |
| upd_count | output | 12 | Cumulative credit limit to advertise |
| upd_ack | input | 1 | Transmitter has taken the request |

## Verification
The bench builds the block with a 256-byte payload, so posted data starts at 16 credits. It sets refresh windows of 40 and 160 cycles in place of the thousands of cycles that real microsecond windows would need at the default parameters. With these short windows, both refresh modes, the simultaneous expiry of all four timers and the priority order among them are reached within a few hundred cycles. The same settings leave room for thousands of consume and release rounds, which carry the header and data counts past their wrap points.

// File: rtl/fcadv_pkg.sv
package fcadv_pkg;
    localparam int FC_KINDS  = 4;
    localparam int KIND_W    = 2;
    localparam int HDR_W     = 8;
    localparam int DAT_W     = 12;
    localparam int AMT_W     = 12;

    typedef enum logic [KIND_W-1:0] {
        FC_PH  = 2'd0,
        FC_PD  = 2'd1,
        FC_NPH = 2'd2,
        FC_NPD = 2'd3
    } fc_kind_e;

    function automatic bit kind_is_hdr(int k);
        return (k == int'(FC_PH)) || (k == int'(FC_NPH));
    endfunction
endpackage

// File: rtl/fcadv_credit_slot.sv
module fcadv_credit_slot #(
    parameter int CNT_W = 8,
    parameter int INIT  = 2,
    parameter int AMT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cons_hit,
    input  logic [AMT_W-1:0] cons_amt,
    input  logic             rel_hit,
    input  logic [AMT_W-1:0] rel_amt,
    output logic             rel_ok,
    output logic [AMT_W-1:0] adv_cnt
);
    localparam logic [CNT_W-1:0] INIT_C = CNT_W'(INIT);

    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] taken;
    } slot_t;

    slot_t st_d, st_q;
    logic  cons_fits, rel_fits, cons_ok;
    logic [CNT_W-1:0] avail, held, c_amt, r_amt;

    generate
        if (CNT_W < AMT_W) begin : g_narrow
            assign cons_fits = ~|cons_amt[AMT_W-1:CNT_W];
            assign rel_fits  = ~|rel_amt[AMT_W-1:CNT_W];
        end else begin : g_full
            assign cons_fits = 1'b1;
            assign rel_fits  = 1'b1;
        end
    endgenerate

    always_comb begin
        c_amt   = cons_amt[CNT_W-1:0];
        r_amt   = rel_amt[CNT_W-1:0];
        avail   = st_q.lim - st_q.taken;
        held    = st_q.taken - (st_q.lim - INIT_C);
        cons_ok = cons_hit && cons_fits && (c_amt <= avail);
        rel_ok  = rel_hit && rel_fits && (r_amt != '0) && (r_amt <= held);
        st_d       = st_q;
        if (cons_ok) st_d.taken = st_q.taken + c_amt;
        if (rel_ok)  st_d.lim   = st_q.lim + r_amt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lim   <= INIT_C;
            st_q.taken <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adv_cnt = AMT_W'(st_q.lim);

    // R3
    avail_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(st_q.lim - st_q.taken) <= INIT_C);

    // R5
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_hit |=> $stable(adv_cnt));
endmodule

// File: rtl/fcadv_refresh_timer.sv
module fcadv_refresh_timer #(
    parameter int SHORT_CYC = 7500,
    parameter int LONG_CYC  = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic long_mode,
    input  logic restart,
    output logic due
);
    localparam int TW = $clog2(LONG_CYC + 1);
    localparam logic [TW-1:0] SHORT_T = TW'(SHORT_CYC);
    localparam logic [TW-1:0] LONG_T  = TW'(LONG_CYC);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [TW-1:0] limit;

    always_comb begin
        limit = long_mode ? LONG_T : SHORT_T;
        st_d  = st_q;
        if (!link_up || restart)   st_d.tmr = '0;
        else if (st_q.tmr < limit) st_d.tmr = st_q.tmr + 1'b1;
        due = link_up && (st_q.tmr >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= LONG_T);

    // R10
    tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (st_q.tmr == '0));
endmodule

// File: rtl/fcadv_arbiter.sv
module fcadv_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic [N-1:0]  pending,
    input  logic          ack,
    output logic          req,
    output logic [IW-1:0] sel,
    output logic [N-1:0]  grant
);
    typedef struct packed {
        logic          lock;
        logic [IW-1:0] sel;
    } arb_t;

    arb_t st_d, st_q;
    logic [IW-1:0] pri;

    always_comb begin
        pri = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) pri = IW'(i);
        end
        req   = link_up && (|pending);
        sel   = (st_q.lock && pending[st_q.sel]) ? st_q.sel : pri;
        grant = (req && ack) ? (N'(1) << sel) : '0;
        st_d.lock = req && !ack;
        st_d.sel  = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (!link_up || (req && $stable(sel))));

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pending) == '0);
endmodule

// File: rtl/rx_fc_advertiser.sv
module rx_fc_advertiser #(
    parameter int MAX_PAYLOAD_BYTES = 256,
    parameter int REFRESH_SHORT_CYC = 7500,
    parameter int REFRESH_LONG_CYC  = 30000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        ext_sync,
    input  logic        cons_vld,
    input  logic [1:0]  cons_kind,
    input  logic [11:0] cons_amt,
    input  logic        rel_vld,
    input  logic [1:0]  rel_kind,
    input  logic [11:0] rel_amt,
    output logic        upd_req,
    output logic [1:0]  upd_kind,
    output logic [11:0] upd_count,
    input  logic        upd_ack
);
    import fcadv_pkg::*;

    localparam int PD_INIT = MAX_PAYLOAD_BYTES / 16;

    typedef struct packed {
        logic [FC_KINDS-1:0] pend;
    } top_t;

    top_t st_d, st_q;
    logic [FC_KINDS-1:0] rel_ok, due, grant;
    logic [AMT_W-1:0]    adv [FC_KINDS];

    for (genvar k = 0; k < FC_KINDS; k++) begin : g_kind
        localparam int K_W    = kind_is_hdr(k) ? HDR_W : DAT_W;
        localparam int K_INIT = (k == int'(FC_PD)) ? PD_INIT : 2;

        fcadv_credit_slot #(.CNT_W(K_W), .INIT(K_INIT), .AMT_W(AMT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cons_hit (cons_vld && (cons_kind == KIND_W'(k))),
            .cons_amt (cons_amt),
            .rel_hit  (rel_vld && (rel_kind == KIND_W'(k))),
            .rel_amt  (rel_amt),
            .rel_ok   (rel_ok[k]),
            .adv_cnt  (adv[k])
        );

        fcadv_refresh_timer #(.SHORT_CYC(REFRESH_SHORT_CYC), .LONG_CYC(REFRESH_LONG_CYC)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .link_up   (link_up),
            .long_mode (ext_sync),
            .restart   (grant[k]),
            .due       (due[k])
        );
    end

    fcadv_arbiter #(.N(FC_KINDS), .IW(KIND_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .pending (st_q.pend),
        .ack     (upd_ack),
        .req     (upd_req),
        .sel     (upd_kind),
        .grant   (grant)
    );

    always_comb begin
        st_d.pend = (st_q.pend & ~grant) | rel_ok | (due & ~grant);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_count = adv[upd_kind];

    // R4
    rel_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_ok) |=> (upd_req || !link_up));
endmodule

// File: tb/rx_fc_advertiser_bench.sv
module rx_fc_advertiser_bench;
    localparam int MPS   = 256;
    localparam int SHORT = 40;
    localparam int LONG  = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0, ext_sync = 1'b0;
    logic        cons_vld = 1'b0, rel_vld = 1'b0, upd_ack = 1'b0;
    logic [1:0]  cons_kind = '0, rel_kind = '0;
    logic [11:0] cons_amt = '0, rel_amt = '0;
    logic        upd_req;
    logic [1:0]  upd_kind;
    logic [11:0] upd_count;

    always #10 clk = ~clk;

    rx_fc_advertiser #(.MAX_PAYLOAD_BYTES(MPS), .REFRESH_SHORT_CYC(SHORT),
                       .REFRESH_LONG_CYC(LONG)) u_rx_fc_advertiser (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .ext_sync(ext_sync),
        .cons_vld(cons_vld), .cons_kind(cons_kind), .cons_amt(cons_amt),
        .rel_vld(rel_vld), .rel_kind(rel_kind), .rel_amt(rel_amt),
        .upd_req(upd_req), .upd_kind(upd_kind), .upd_count(upd_count),
        .upd_ack(upd_ack));

    int n_chk = 0, n_bad = 0;
    int m_lim[4], m_taken[4], init_v[4], last_cnt[4];
    bit last_cacc, last_racc;

    function automatic int msk(int k);
        return (k == 0 || k == 2) ? 255 : 4095;
    endfunction
    function automatic int avail_of(int k);
        return (m_lim[k] - m_taken[k]) & msk(k);
    endfunction
    function automatic int held_of(int k);
        return (m_taken[k] - (m_lim[k] - init_v[k])) & msk(k);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(bit cv, int ck, int ca, bit rv, int rk, int ra);
        bit ca_ok, ra_ok;
        ca_ok = cv && (ca <= msk(ck)) && (ca <= avail_of(ck));
        ra_ok = rv && (ra != 0) && (ra <= msk(rk)) && (ra <= held_of(rk));
        if (ca_ok) m_taken[ck] = (m_taken[ck] + ca) & msk(ck);
        if (ra_ok) m_lim[rk]   = (m_lim[rk] + ra) & msk(rk);
        last_cacc = ca_ok;
        last_racc = ra_ok;
        cons_vld = cv; cons_kind = 2'(ck); cons_amt = 12'(ca);
        rel_vld  = rv; rel_kind  = 2'(rk); rel_amt  = 12'(ra);
        @(negedge clk);
        cons_vld = 1'b0; rel_vld = 1'b0;
    endtask

    task automatic ack_one();
        upd_ack = 1'b1;
        @(negedge clk);
        upd_ack = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 12 && upd_req; i++) begin
            chk(int'(upd_count) == m_lim[upd_kind], "R4 advertised count",
                int'(upd_count), m_lim[upd_kind]);
            last_cnt[upd_kind] = int'(upd_count);
            ack_one();
        end
    endtask

    task automatic go_quiet();
        drain();
        link_up = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(upd_req == 1'b0, "R10 no request while link down", int'(upd_req), 0);
    endtask

    task automatic fresh();
        go_quiet();
        link_up = 1'b1;
    endtask

    task automatic measure(int exp_n, string tag);
        int n;
        n = 0;
        while (!upd_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, tag, n, exp_n);
    endtask

    task automatic settle_all();
        for (int k = 0; k < 4; k++) begin
            if (held_of(k) > 0) apply(1'b0, 0, 0, 1'b1, k, held_of(k));
            drain();
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        init_v[0] = 2; init_v[1] = MPS / 16; init_v[2] = 2; init_v[3] = 2;
        for (int k = 0; k < 4; k++) begin
            m_lim[k] = init_v[k]; m_taken[k] = 0; last_cnt[k] = -1;
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(upd_req == 1'b0, "R1 request low after reset", int'(upd_req), 0);

        // R9 short window, R7 order, R2 initial counts
        link_up = 1'b1;
        measure(SHORT + 1, "R9 short refresh delay");
        for (int k = 0; k < 4; k++) begin
            chk(upd_req && int'(upd_kind) == k, "R7 priority order", int'(upd_kind), k);
            chk(int'(upd_count) == init_v[k], "R2 initial count", int'(upd_count), init_v[k]);
            ack_one();
        end

        // R5 and R3 ignored operations
        fresh();
        apply(1'b0, 0, 0, 1'b1, 0, 1);
        chk(upd_req == 1'b0, "R5 release with nothing in use", int'(upd_req), 0);
        apply(1'b1, 1, 5, 1'b0, 0, 0);
        apply(1'b0, 0, 0, 1'b1, 1, 0);
        chk(upd_req == 1'b0, "R5 zero release", int'(upd_req), 0);
        apply(1'b0, 0, 0, 1'b1, 1, 6);
        chk(upd_req == 1'b0, "R5 release above in-use", int'(upd_req), 0);
        apply(1'b1, 2, 3, 1'b0, 0, 0);
        apply(1'b0, 0, 0, 1'b1, 2, 1);
        chk(upd_req == 1'b0, "R3 over-consume ignored", int'(upd_req), 0);
        apply(1'b1, 2, 2, 1'b0, 0, 0);
        apply(1'b0, 0, 0, 1'b1, 2, 2);
        chk(upd_req && upd_kind == 2'd2 && upd_count == 12'd4, "R4 release advances count",
            int'(upd_count), 4);
        drain();

        // R8 lock against a higher-priority arrival
        fresh();
        apply(1'b1, 3, 2, 1'b0, 0, 0);
        apply(1'b1, 0, 1, 1'b1, 3, 1);
        chk(upd_req && upd_kind == 2'd3, "R8 first request kind", int'(upd_kind), 3);
        apply(1'b0, 0, 0, 1'b1, 0, 1);
        for (int i = 0; i < 3; i++) begin
            chk(upd_req && upd_kind == 2'd3, "R8 held kind", int'(upd_kind), 3);
            @(negedge clk);
        end
        ack_one();
        chk(upd_req && upd_kind == 2'd0, "R7 waiting kind follows", int'(upd_kind), 0);
        drain();

        // R9 long window
        go_quiet();
        ext_sync = 1'b1;
        link_up = 1'b1;
        measure(LONG + 1, "R9 long refresh delay");
        drain();
        ext_sync = 1'b0;

        // R10 release during link down waits
        go_quiet();
        apply(1'b1, 1, 3, 1'b0, 0, 0);
        apply(1'b0, 0, 0, 1'b1, 1, 3);
        for (int i = 0; i < 3; i++) begin
            chk(upd_req == 1'b0, "R10 held while down", int'(upd_req), 0);
            @(negedge clk);
        end
        link_up = 1'b1;
        @(negedge clk);
        chk(upd_req && upd_kind == 2'd1 && int'(upd_count) == m_lim[1],
            "R10 pending shown on link return", int'(upd_count), m_lim[1]);
        drain();

        // R4 random traffic
        for (int it = 0; it < 400; it++) begin
            int ck, rk, ca, ra;
            ck = $urandom_range(0, 3);
            rk = $urandom_range(0, 3);
            ca = $urandom_range(0, avail_of(ck) + 2);
            ra = $urandom_range(0, held_of(rk) + 2);
            apply($urandom_range(0, 3) != 0, ck, ca, $urandom_range(0, 3) != 0, rk, ra);
            if (last_racc)
                chk(upd_req == 1'b1, "R4 request after release", int'(upd_req), 1);
            drain();
        end

        // R6 wrap of header and data counts
        settle_all();
        base = m_lim[0];
        for (int it = 0; it < 300; it++) begin
            apply(1'b1, 0, 1, 1'b0, 0, 0);
            apply(1'b0, 0, 0, 1'b1, 0, 1);
            drain();
        end
        chk(last_cnt[0] == ((base + 300) & 255), "R6 header wrap", last_cnt[0],
            (base + 300) & 255);
        base = m_lim[3];
        for (int it = 0; it < 2100; it++) begin
            apply(1'b1, 3, 2, 1'b0, 0, 0);
            apply(1'b0, 0, 0, 1'b1, 3, 2);
            drain();
        end
        chk(last_cnt[3] == ((base + 4200) & 4095), "R6 data wrap", last_cnt[3],
            (base + 4200) & 4095);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule